// File: doc/BRIEF.md
# Reset-Cause Status and Control Register

This block is an eight-bit processor status and control register. It records why the core last restarted. It also tracks whether the core runs, whether it has asked to suspend, and whether interrupts are enabled or pending. Other logic feeds it qualified single-cycle pulses: power-on or low-voltage reset, watchdog rollover, and a bus event that has already been filtered for duration. It also receives the decoded EI, DI, RETI and HALT instructions, a resume level and a pending-interrupt level. Firmware reads the register and writes it through a simple one-cycle write port.

The three reset-cause flags are sticky. Hardware sets them, and firmware clears each one by writing 0 to it, while writing 1 leaves it alone. The interrupt-enable bit and the run bit follow instructions only, and register writes do not touch them. The suspend bit is set by firmware and cleared only by hardware when a resume condition is seen. The block drives a halt level, a suspend request and a global interrupt-enable level from this state.

Top module: `rstcause_csr`

## Requirements
- R1: Both the asynchronous reset (rst_n low) and a power/low-voltage pulse (lvr_evt) load the register with 8'b0001_0001 in bits 6..0. That means run (bit 0) and the low-voltage flag (bit 4) are 1 and everything else is 0. The load is visible one cycle after the pulse.
- R2: Bit 7 of rd_data always equals irq_pend, and bit 1 always reads 0. Writes have no effect on either bit.
- R3: A watchdog pulse (wdt_evt) without lvr_evt makes the next register value set bit 6 and set bit 0. It clears bits 5, 3 and 2 and keeps bit 4 unchanged, so a watchdog after power-up reads 8'b0101_0001. Any write in the same cycle is ignored. When lvr_evt and wdt_evt arrive together, the power-up load of R1 wins.
- R4: A bus_evt pulse sets bit 5 in the next cycle, whatever the interrupt-enable state.
- R5: A write with wr_en high clears bit 4, 5 or 6 when the written data bit is 0 and leaves it unchanged when that bit is 1. A bus_evt in the same cycle as a clear of bit 5 leaves bit 5 at 1.
- R6: Writing 1 to bit 3 sets it in the next cycle, which raises suspend_req and halted. Writing 0 to bit 3 has no effect.
- R7: While bit 3 is 1, resume_req high clears it in the next cycle. If resume_req is already high when bit 3 is written, bit 3 reads 1 for exactly one cycle and then clears.
- R8: Bit 2 is set by ei_op or reti_op and cleared by di_op, and di_op wins when it coincides with ei_op. Writes do not change bit 2, and gie always equals bit 2.
- R9: halt_op clears bit 0 (run) in the next cycle, and halted stays high until a watchdog or power/low-voltage reset sets run again. Writes do not change bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, same effect as a power/low-voltage load |
| lvr_evt | input | 1 | Power-on / low-voltage / brown-out reset pulse |
| wdt_evt | input | 1 | Watchdog rollover pulse |
| bus_evt | input | 1 | Qualified bus-activity event pulse |
| resume_req | input | 1 | Resume condition level (interrupt or bus activity) |
| ei_op | input | 1 | Enable-interrupts instruction pulse |
| di_op | input | 1 | Disable-interrupts instruction pulse |
| reti_op | input | 1 | Return-from-interrupt instruction pulse |
| halt_op | input | 1 | Halt instruction pulse |
| irq_pend | input | 1 | Pending-interrupt level |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| halted | output | 1 | Core stopped: run clear or suspend set |
| suspend_req | output | 1 | Suspend request to clock control |
| gie | output | 1 | Global interrupt-enable level |

## Verification
The assertions assume that lvr_evt and wdt_evt are single-cycle pulses. They also assume that these reset pulses take precedence over every other input, so each property about writes or instructions excludes cycles in which either reset pulse is high. The bench keeps within these assumptions. It drives every input just after a falling edge and holds it for exactly one rising edge. It raises the reset pulses alone, except in the one deliberate check where both coincide. It re-establishes a known state with lvr_evt before each sweep step.

// File: rtl/rcsr_pkg.sv
package rcsr_pkg;
  localparam int REG_W     = 8;
  localparam int B_IRQ     = 7;
  localparam int B_WDR     = 6;
  localparam int B_BUS     = 5;
  localparam int B_LVR     = 4;
  localparam int B_SUSP    = 3;
  localparam int B_IEN     = 2;
  localparam int B_RSV     = 1;
  localparam int B_RUN     = 0;
  localparam int FLAG_LO   = B_LVR;
  localparam int NUM_FLAGS = B_WDR - B_LVR + 1;
  localparam logic [REG_W-1:0] POR_VALUE = 8'b0001_0001;

  typedef enum logic [1:0] {WD_KEEP, WD_CLEAR, WD_SET} wd_act_e;

  // sticky flag: hardware set dominates a firmware clear
  function automatic logic sticky_next(logic cur, logic hw_set, logic fw_clr);
    return hw_set | (cur & ~fw_clr);
  endfunction

  // suspend: once set, only a resume clears it; when clear, a write request sets it
  function automatic logic suspend_next(logic cur, logic req, logic resume);
    return cur ? ~resume : req;
  endfunction

  // interrupt-enable sense: DI dominates EI/RETI
  function automatic logic ien_next(logic cur, logic ei, logic di, logic reti);
    return di ? 1'b0 : ((ei | reti) ? 1'b1 : cur);
  endfunction

  // per-flag configuration, index 0 is the lowest cause flag
  function automatic logic flag_por(int idx);
    return (FLAG_LO + idx) == B_LVR;
  endfunction

  function automatic wd_act_e flag_wd(int idx);
    if ((FLAG_LO + idx) == B_WDR) return WD_SET;
    if ((FLAG_LO + idx) == B_BUS) return WD_CLEAR;
    return WD_KEEP;
  endfunction
endpackage

// File: rtl/rcsr_sticky_flag.sv
module rcsr_sticky_flag
  import rcsr_pkg::*;
#(
  parameter logic    POR_VAL = 1'b0,
  parameter wd_act_e WD_ACT  = WD_KEEP
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvr_load,
  input  logic wdt_load,
  input  logic hw_set,
  input  logic fw_clr,
  output logic q
);
  logic wd_val;

  always_comb begin
    if (WD_ACT == WD_SET)        wd_val = 1'b1;
    else if (WD_ACT == WD_CLEAR) wd_val = 1'b0;
    else                         wd_val = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= POR_VAL;
    else if (lvr_load) q <= POR_VAL;
    else if (wdt_load) q <= wd_val;
    else               q <= sticky_next(q, hw_set, fw_clr);
  end
endmodule

// File: rtl/rcsr_exec_ctl.sv
module rcsr_exec_ctl
  import rcsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic core_reset,
  input  logic susp_wr,
  input  logic resume_req,
  input  logic ei_op,
  input  logic di_op,
  input  logic reti_op,
  input  logic halt_op,
  output logic susp_q,
  output logic ien_q,
  output logic run_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_q <= POR_VALUE[B_SUSP];
      ien_q  <= POR_VALUE[B_IEN];
      run_q  <= POR_VALUE[B_RUN];
    end else if (core_reset) begin
      susp_q <= POR_VALUE[B_SUSP];
      ien_q  <= POR_VALUE[B_IEN];
      run_q  <= POR_VALUE[B_RUN];
    end else begin
      susp_q <= suspend_next(susp_q, susp_wr, resume_req);
      ien_q  <= ien_next(ien_q, ei_op, di_op, reti_op);
      run_q  <= run_q & ~halt_op;
    end
  end
endmodule

// File: rtl/rstcause_csr.sv
module rstcause_csr
  import rcsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvr_evt,
  input  logic             wdt_evt,
  input  logic             bus_evt,
  input  logic             resume_req,
  input  logic             ei_op,
  input  logic             di_op,
  input  logic             reti_op,
  input  logic             halt_op,
  input  logic             irq_pend,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             halted,
  output logic             suspend_req,
  output logic             gie
);
  // named internal events
  logic                 wdt_only;
  logic                 core_reset;
  logic                 susp_wr;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_clr;
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 susp_q, ien_q, run_q;

  assign wdt_only   = wdt_evt & ~lvr_evt;
  assign core_reset = lvr_evt | wdt_evt;
  assign susp_wr    = wr_en & wr_data[B_SUSP];

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assign flag_set[i] = ((FLAG_LO + i) == B_BUS) ? bus_evt : 1'b0;
    assign flag_clr[i] = wr_en & ~wr_data[FLAG_LO + i];
    rcsr_sticky_flag #(
      .POR_VAL (flag_por(i)),
      .WD_ACT  (flag_wd(i))
    ) u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvr_load (lvr_evt),
      .wdt_load (wdt_only),
      .hw_set   (flag_set[i]),
      .fw_clr   (flag_clr[i]),
      .q        (flag_q[i])
    );
  end

  rcsr_exec_ctl u_exec (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_reset (core_reset),
    .susp_wr    (susp_wr),
    .resume_req (resume_req),
    .ei_op      (ei_op),
    .di_op      (di_op),
    .reti_op    (reti_op),
    .halt_op    (halt_op),
    .susp_q     (susp_q),
    .ien_q      (ien_q),
    .run_q      (run_q)
  );

  always_comb begin
    rd_data                        = '0;
    rd_data[B_IRQ]                 = irq_pend;
    rd_data[B_WDR:B_LVR]           = flag_q;
    rd_data[B_SUSP]                = susp_q;
    rd_data[B_IEN]                 = ien_q;
    rd_data[B_RSV]                 = 1'b0;
    rd_data[B_RUN]                 = run_q;
  end

  assign halted      = ~run_q | susp_q;
  assign suspend_req = susp_q;
  assign gie         = ien_q;
endmodule

// File: rtl/rcsr_checker.sv
module rcsr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       lvr_evt,
  input logic       wdt_evt,
  input logic       bus_evt,
  input logic       resume_req,
  input logic       ei_op,
  input logic       di_op,
  input logic       halt_op,
  input logic       irq_pend,
  input logic       wr_en,
  input logic [6:3] wr_hi,
  input logic [7:0] rd_data
);
  logic quiet;
  assign quiet = ~lvr_evt & ~wdt_evt;

  p_lvr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lvr_evt |=> rd_data[6:0] == 7'b001_0001);

  p_irq_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] == irq_pend && rd_data[1] == 1'b0);

  p_wdt_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_evt && !lvr_evt) |=> (rd_data[6] && rd_data[0] && !rd_data[5]
                               && !rd_data[3] && !rd_data[2]
                               && rd_data[4] == $past(rd_data[4])));

  p_bus_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_evt && quiet) |=> rd_data[5]);

  p_wdr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !(wr_en && !wr_hi[6])) |=> rd_data[6] == $past(rd_data[6]));

  p_bus_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !bus_evt && !(wr_en && !wr_hi[5])) |=> rd_data[5] == $past(rd_data[5]));

  p_lvr_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !(wr_en && !wr_hi[4])) |=> rd_data[4] == $past(rd_data[4]));

  p_susp_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !rd_data[3] && wr_en && wr_hi[3]) |=> rd_data[3]);

  p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && rd_data[3] && resume_req) |=> !rd_data[3]);

  p_ien_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && ei_op && !di_op) |=> rd_data[2]);

  p_di_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && di_op) |=> !rd_data[2]);

  p_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && halt_op) |=> !rd_data[0]);

  p_run_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !rd_data[0]) |=> !rd_data[0]);
endmodule

bind rstcause_csr rcsr_checker u_rcsr_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .lvr_evt    (lvr_evt),
  .wdt_evt    (wdt_evt),
  .bus_evt    (bus_evt),
  .resume_req (resume_req),
  .ei_op      (ei_op),
  .di_op      (di_op),
  .halt_op    (halt_op),
  .irq_pend   (irq_pend),
  .wr_en      (wr_en),
  .wr_hi      (wr_data[6:3]),
  .rd_data    (rd_data)
);

// File: tb/rstcause_csr_bench.sv
module rstcause_csr_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lvr_evt = 1'b0, wdt_evt = 1'b0, bus_evt = 1'b0, resume_req = 1'b0;
  logic       ei_op = 1'b0, di_op = 1'b0, reti_op = 1'b0, halt_op = 1'b0;
  logic       irq_pend = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       halted, suspend_req, gie;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rstcause_csr u_rstcause_csr (
    .clk(clk), .rst_n(rst_n), .lvr_evt(lvr_evt), .wdt_evt(wdt_evt),
    .bus_evt(bus_evt), .resume_req(resume_req), .ei_op(ei_op), .di_op(di_op),
    .reti_op(reti_op), .halt_op(halt_op), .irq_pend(irq_pend), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .halted(halted),
    .suspend_req(suspend_req), .gie(gie)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one rising edge with the currently driven inputs, then drop the pulses
  task automatic step();
    @(negedge clk);
    lvr_evt = 0; wdt_evt = 0; bus_evt = 0; ei_op = 0; di_op = 0;
    reti_op = 0; halt_op = 0; wr_en = 0;
  endtask

  task automatic wr(logic [7:0] v);
    wr_en = 1; wr_data = v; step();
  endtask

  task automatic por();
    lvr_evt = 1; step();
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 asynchronous reset state
    chk("R1 reset value", rd_data, 8'h11);
    chk("R1 reset outputs", {5'b0, halted, suspend_req, gie}, 8'h00);
    rst_n = 1; @(negedge clk);

    // R2 irq mirror, reserved bit, R5 firmware clear
    irq_pend = 1; #1;
    chk("R2 irq mirror", rd_data, 8'h91);
    wr(8'h82);
    irq_pend = 0; #1;
    chk("R2 R5 write clears lvr flag, bit1/bit7 unaffected", rd_data, 8'h01);

    // R3 watchdog after power-up
    por(); wdt_evt = 1; step();
    chk("R3 watchdog after power-up", rd_data, 8'h51);

    // R3 watchdog clears suspend, bus flag, ien, keeps lvr
    por(); ei_op = 1; step();
    wr(8'h18); bus_evt = 1; step();
    chk("R3 R4 state before watchdog", rd_data, 8'h3D);
    wdt_evt = 1; wr_en = 1; wr_data = 8'h08; step();
    chk("R3 watchdog clear/keep set", rd_data, 8'h51);
    wdt_evt = 1; wr_en = 1; wr_data = 8'h00; step();
    chk("R3 watchdog keeps cleared-not lvr", rd_data, 8'h51);

    // R3 simultaneous lvr and watchdog
    lvr_evt = 1; wdt_evt = 1; step();
    chk("R3 lvr wins over watchdog", rd_data, 8'h11);

    // R5 bus set beats clear, write 1 keeps
    bus_evt = 1; wr_en = 1; wr_data = 8'h00; step();
    chk("R5 hw set beats fw clear", rd_data, 8'h21);
    wr(8'h70);
    chk("R5 write ones keeps flags", rd_data, 8'h21);

    // R6 / R7 suspend
    por(); wr(8'h08);
    chk("R6 suspend set", rd_data, 8'h09);
    chk("R6 suspend outputs", {6'b0, halted, suspend_req}, 8'h03);
    wr(8'h00);
    chk("R6 write 0 keeps suspend", rd_data, 8'h09);
    resume_req = 1; step();
    chk("R7 resume clears suspend", rd_data, 8'h01);
    chk("R7 suspend_req released", {7'b0, suspend_req}, 8'h00);
    wr(8'h08);
    chk("R7 suspend entered with resume present", {7'b0, suspend_req}, 8'h01);
    step();
    chk("R7 immediate wake-up", rd_data, 8'h01);
    resume_req = 0;

    // R8 interrupt-enable sense
    por();
    ei_op = 1; step();
    chk("R8 EI sets", {rd_data[2], gie}, 2'b11);
    di_op = 1; step();
    chk("R8 DI clears", {rd_data[2], gie}, 2'b00);
    reti_op = 1; step();
    chk("R8 RETI sets", {rd_data[2], gie}, 2'b11);
    ei_op = 1; di_op = 1; step();
    chk("R8 DI wins over EI", {rd_data[2], gie}, 2'b00);
    wr(8'h04);
    chk("R8 write ignored", rd_data, 8'h01);

    // R9 halt
    por(); halt_op = 1; step();
    chk("R9 halt clears run", rd_data, 8'h10);
    chk("R9 halted high", {7'b0, halted}, 8'h01);
    wr(8'h11);
    step(); step();
    chk("R9 write and time do not restart", rd_data, 8'h10);
    wdt_evt = 1; step();
    chk("R9 watchdog restarts", rd_data, 8'h51);
    chk("R9 halted released", {7'b0, halted}, 8'h00);

    // R1 async reset from a busy state
    ei_op = 1; bus_evt = 1; step();
    rst_n = 0; #1;
    chk("R1 async reset mid-run", rd_data, 8'h11);
    @(negedge clk); rst_n = 1; @(negedge clk);

    // sweep: all flags set, then every write value
    for (int v = 0; v < 256; v++) begin
      por(); wdt_evt = 1; step(); bus_evt = 1; step();
      irq_pend = v[0];
      wr(v[7:0]);
      chk("R2 R5 R6 write sweep", rd_data,
          {v[0], v[6], v[5], v[4], v[3], 1'b0, 1'b0, 1'b1});
    end
    irq_pend = 0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule